// File: doc/BRIEF.md
# Control Register Target on a Two-Wire Serial Bus

This block is a target on a two-wire serial bus (SCL clock, SDA data, open-drain). It holds a small bank of 8-bit control registers whose contents leave the block as one flat parallel vector. The block watches the bus for START and STOP conditions and checks the first byte against a hard-wired 7-bit device address. On a write, the second byte selects a register. Each byte after that is stored in the selected register, and the register pointer then moves to the next register. A read shifts out the register at the pointer and advances the pointer each time the controller acknowledges.

SCL and SDA are resynchronised into the system clock domain, and all bus events are found from edges of the synchronised lines. The system clock must run at least 20 times faster than SCL; the bus is standard mode, up to 100 kHz. The block never drives SDA high. It only pulls SDA low, or releases it, through `sda_oe_o`, which the pad turns into an open-drain driver.

Top module: `ctrl_reg_target`

## Requirements
- R1: After reset all nine registers (00h..08h) read zero on `regs_o` and `sda_oe_o` is 0 (SDA released).
- R2: The first byte after START is a 7-bit address, MSB first, followed by a direction bit (0 = write, 1 = read). When the address equals 7'b0010001, SDA is pulled low during the ninth SCL clock.
- R3: For any other address, SDA is never pulled low and no register changes until the next START or STOP.
- R4: In a write, the byte after the address is the register pointer, MSB first. Its low five bits select the register. It is acknowledged on the ninth clock.
- R5: Each data byte after the pointer byte is received MSB first and written to the register at the pointer (register n at `regs_o[8n+7:8n]`). It is acknowledged on the ninth clock. No register changes at any other time.
- R6: After each data byte the pointer increments by one, so a burst fills consecutive registers.
- R7: From pointer 08h, the pointer returns to 00h, and later bytes in the same burst overwrite registers written earlier.
- R8: A pointer above 08h is acknowledged, and data bytes sent to it are acknowledged but leave every register unchanged. The pointer then continues at 00h.
- R9: A repeated START at any point releases SDA and restarts address reception.
- R10: After a matching address with direction bit 1, the register at the pointer is shifted out MSB first. After a controller acknowledge (SDA low on the ninth clock) the pointer advances, with the same 08h-to-00h wrap, and the next register follows. After a not-acknowledge the target releases the bus.
- R11: The target starts pulling SDA low only while SCL is low.
- R12: A STOP releases SDA and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 20x SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_o | output | 72 | Register n at bits [8n+7:8n], n = 0..8 |

## Verification
The assertions check every cycle that SDA is only newly pulled low while the synchronised SCL is low. They also check that START and STOP release the line, that register writes land only on existing registers and only at SCL-low instants, and that the register outputs hold between writes. Only the bench scenarios show the rest. These are the bit ordering and address decoding, the acknowledge on the ninth clock, the pointer's increment and wrap in both directions, the silence after a foreign address, and the data shifted out during reads.

// File: rtl/ctrl_reg_pkg.sv
package ctrl_reg_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_SKIP
  } link_state_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/crt_bus_sampler.sv
module crt_bus_sampler #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic [MSB:0] scl_pipe, sda_pipe;
  logic         scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[MSB-1:0], scl_i};
      sda_pipe <= {sda_pipe[MSB-1:0], sda_i};
      scl_d    <= scl_pipe[MSB];
      sda_d    <= sda_pipe[MSB];
    end
  end

  assign scl_o      = scl_pipe[MSB];
  assign sda_o      = sda_pipe[MSB];
  assign scl_rise_o = !scl_d && scl_o;
  assign scl_fall_o = scl_d && !scl_o;
  // data edges qualified by SCL high on both samples
  assign start_o    = scl_d && scl_o && sda_d && !sda_o;
  assign stop_o     = scl_d && scl_o && !sda_d && sda_o;
endmodule

// File: rtl/crt_reg_store.sv
module crt_reg_store #(
  parameter int unsigned NUM_REGS = 9,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned PTR_W    = 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [PTR_W-1:0]           wr_addr_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  input  logic [PTR_W-1:0]           rd_addr_i,
  output logic [DATA_W-1:0]          rd_data_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  logic [DATA_W-1:0] mem_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  mem_q[g] <= '0;
      else if (we_i && wr_addr_i == PTR_W'(g))      mem_q[g] <= wr_data_i;
    end
    assign regs_o[g*DATA_W +: DATA_W] = mem_q[g];
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_addr_i == PTR_W'(i)) rd_data_o = mem_q[i];
    end
  end
endmodule

// File: rtl/crt_link_fsm.sv
module crt_link_fsm
  import ctrl_reg_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'b0010001,
  parameter int unsigned NUM_REGS = 9,
  parameter int unsigned PTR_W    = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sda_i,
  input  logic               scl_rise_i,
  input  logic               scl_fall_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic [BYTE_W-1:0]  rd_data_i,
  output logic [PTR_W-1:0]   rd_addr_o,
  output logic               we_o,
  output logic [PTR_W-1:0]   wr_addr_o,
  output logic [BYTE_W-1:0]  wr_data_o,
  output logic               sda_oe_o
);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(NUM_REGS - 1);

  link_state_e       state_q;
  logic [3:0]        cnt_q;
  logic [BYTE_W-1:0] rx_q, tx_q;
  logic [PTR_W-1:0]  ptr_q, ptr_nxt;
  logic              rw_q, mack_q, oe_q;
  logic              byte_done;

  assign ptr_nxt   = (ptr_q >= LAST_IDX) ? '0 : ptr_q + 1'b1;
  assign byte_done = scl_fall_i && (cnt_q == 4'd8);
  assign rd_addr_o = (state_q == ST_RD_ACK) ? ptr_nxt : ptr_q;
  assign we_o      = (state_q == ST_WR) && byte_done && !start_i && !stop_i
                     && (ptr_q <= LAST_IDX);
  assign wr_addr_o = ptr_q;
  assign wr_data_o = rx_q;
  assign sda_oe_o  = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_SUB, ST_WR: begin
          if (scl_rise_i && cnt_q != 4'd8) begin
            rx_q  <= {rx_q[BYTE_W-2:0], sda_i};
            cnt_q <= cnt_q + 1'b1;
          end
          if (byte_done) begin
            cnt_q <= '0;
            if (state_q == ST_ADDR) begin
              if (rx_q[7:1] == DEV_ADDR) begin
                rw_q    <= rx_q[0];
                oe_q    <= 1'b1;
                state_q <= ST_ADDR_ACK;
              end else begin
                state_q <= ST_SKIP;
              end
            end else if (state_q == ST_SUB) begin
              ptr_q   <= rx_q[PTR_W-1:0];
              oe_q    <= 1'b1;
              state_q <= ST_SUB_ACK;
            end else begin
              ptr_q   <= ptr_nxt;
              oe_q    <= 1'b1;
              state_q <= ST_WR_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall_i) begin
            cnt_q <= '0;
            if (rw_q) begin
              tx_q    <= rd_data_i;
              oe_q    <= !rd_data_i[7];
              state_q <= ST_RD;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_SUB;
            end
          end
        end
        ST_SUB_ACK, ST_WR_ACK: begin
          if (scl_fall_i) begin
            cnt_q   <= '0;
            oe_q    <= 1'b0;
            state_q <= ST_WR;
          end
        end
        ST_RD: begin
          if (scl_rise_i) cnt_q <= cnt_q + 1'b1;
          if (byte_done) begin
            oe_q    <= 1'b0;
            state_q <= ST_RD_ACK;
          end else if (scl_fall_i) begin
            tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
            oe_q <= !tx_q[6];
          end
        end
        ST_RD_ACK: begin
          if (scl_rise_i) mack_q <= !sda_i;
          if (scl_fall_i) begin
            cnt_q <= '0;
            if (mack_q) begin
              ptr_q   <= ptr_nxt;
              tx_q    <= rd_data_i;
              oe_q    <= !rd_data_i[7];
              state_q <= ST_RD;
            end else begin
              state_q <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ctrl_reg_target.sv
module ctrl_reg_target
  import ctrl_reg_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'b0010001,
  parameter int unsigned NUM_REGS    = 9,
  parameter int unsigned PTR_W       = 5,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned REGS_W     = NUM_REGS * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [REGS_W-1:0] regs_o
);
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [PTR_W-1:0]  wr_addr, rd_addr;
  logic [BYTE_W-1:0] wr_data, rd_data;

  crt_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) i_sampler (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  crt_link_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) i_fsm (
    .clk_i, .rst_ni, .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det), .rd_data_i(rd_data), .rd_addr_o(rd_addr),
    .we_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .sda_oe_o
  );

  crt_reg_store #(.NUM_REGS(NUM_REGS), .DATA_W(BYTE_W), .PTR_W(PTR_W)) i_store (
    .clk_i, .rst_ni, .we_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .regs_o
  );
endmodule

// File: rtl/ctrl_reg_target_chk.sv
module ctrl_reg_target_chk #(
  parameter int unsigned NUM_REGS = 9,
  parameter int unsigned PTR_W    = 5,
  parameter int unsigned REGS_W   = 72
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_s,
  input logic              start_det,
  input logic              stop_det,
  input logic              wr_en,
  input logic [PTR_W-1:0]  wr_addr,
  input logic              sda_oe_o,
  input logic [REGS_W-1:0] regs_o
);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(NUM_REGS - 1);

  AST_PULL_ON_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s);  // R11
  AST_STOP_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o);  // R12
  AST_START_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !sda_oe_o);  // R9
  AST_WRITE_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> wr_addr <= LAST_IDX);  // R8
  AST_WRITE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> !scl_s);  // R5
  AST_REGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(regs_o));  // R5
endmodule

bind ctrl_reg_target ctrl_reg_target_chk #(
  .NUM_REGS(NUM_REGS), .PTR_W(PTR_W), .REGS_W(REGS_W)
) i_chk (
  .clk_i, .rst_ni, .scl_s, .start_det, .stop_det,
  .wr_en, .wr_addr, .sda_oe_o, .regs_o
);

// File: tb/test_ctrl_reg_target.sv
module test_ctrl_reg_target;
  localparam int Q = 12;
  localparam logic [7:0] AW = 8'h22, AR = 8'h23;

  logic clk = 0, rst_n = 0, scl_drv = 1, sda_drv = 1;
  logic sda_oe;
  logic [71:0] regs;
  wire sda_line = sda_drv & ~sda_oe;
  int n_chk = 0, n_fail = 0, bad_pull = 0;
  logic [7:0] exp_r [9];
  logic prev_oe = 0;

  always #4 clk = ~clk;

  ctrl_reg_target i_ctrl_reg_target (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .regs_o(regs)
  );

  always @(negedge clk) begin
    if (sda_oe && !prev_oe && scl_drv) bad_pull++;
    prev_oe <= sda_oe;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_drv = 1; wq(); scl_drv = 1; wq(); sda_drv = 0; wq(); scl_drv = 0; wq();
  endtask

  task automatic bus_stop();
    sda_drv = 0; wq(); scl_drv = 1; wq(); sda_drv = 1; wq(); wq();
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_drv = b; wq(); scl_drv = 1; wq(); s = sda_line; wq(); scl_drv = 0; wq();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
    clk_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); d[i] = s; end
    clk_bit(!give_ack, s);
    sda_drv = 1;
  endtask

  task automatic check_regs(input string tag);
    logic bad = 0;
    for (int i = 0; i < 9; i++) if (regs[i*8 +: 8] !== exp_r[i]) bad = 1;
    check(!bad, tag, regs[31:0], {exp_r[3], exp_r[2], exp_r[1], exp_r[0]});
  endtask

  task automatic write_burst(input logic [7:0] sub, input logic [7:0] d [], input string tag);
    logic a;
    bus_start();
    send_byte(AW, a); check(a, {tag, " addr ack R2"}, a, 1);
    send_byte(sub, a); check(a, {tag, " sub ack R4"}, a, 1);
    foreach (d[i]) begin
      send_byte(d[i], a); check(a, {tag, " data ack R5"}, a, 1);
    end
    bus_stop();
  endtask

  task automatic t_reset();
    for (int i = 0; i < 9; i++) exp_r[i] = 8'h00;
    check_regs("R1 regs zero");
    check(sda_oe == 0, "R1 sda released", sda_oe, 0);
  endtask

  task automatic t_single();
    write_burst(8'h03, '{8'hA5}, "single");
    exp_r[3] = 8'hA5;
    check_regs("R5 single write");
    check(sda_oe == 0, "R12 released after stop", sda_oe, 0);
  endtask

  task automatic t_burst();
    write_burst(8'h05, '{8'h11, 8'h22, 8'h33}, "burst");
    exp_r[5] = 8'h11; exp_r[6] = 8'h22; exp_r[7] = 8'h33;
    check_regs("R6 burst increments");
  endtask

  task automatic t_wrap();
    logic [7:0] d [] = new[10];
    for (int i = 0; i < 10; i++) d[i] = 8'h40 + 8'(i);
    write_burst(8'h08, d, "wrap");
    for (int i = 0; i < 8; i++) exp_r[i] = 8'h41 + 8'(i);
    exp_r[8] = 8'h49;
    check_regs("R7 wrap overwrite");
  endtask

  task automatic t_high_sub();
    write_burst(8'h1A, '{8'h5C, 8'h6D}, "hisub R8");
    exp_r[0] = 8'h6D;
    check_regs("R8 high pointer ignored then 00h");
  endtask

  task automatic t_bad_addr();
    logic a;
    bus_start();
    send_byte(8'h24, a); check(!a, "R3 foreign addr nack", a, 0);
    send_byte(8'h02, a); check(!a, "R3 no ack after foreign addr", a, 0);
    send_byte(8'hEE, a); check(!a, "R3 no ack data", a, 0);
    check_regs("R3 regs untouched");
    bus_start();
    send_byte(AW, a); check(a, "R3 ack after new start", a, 1);
    send_byte(8'h02, a);
    send_byte(8'h77, a);
    bus_stop();
    exp_r[2] = 8'h77;
    check_regs("R3 write after restart");
  endtask

  task automatic t_rep_start();
    logic a;
    bus_start();
    send_byte(AW, a);
    send_byte(8'h02, a);
    bus_start();
    send_byte(AW, a); check(a, "R9 addr after repeated start", a, 1);
    send_byte(8'h04, a);
    send_byte(8'h99, a);
    bus_stop();
    exp_r[4] = 8'h99;
    check_regs("R9 repeated start restarts");
  endtask

  task automatic t_read();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(AW, a);
    send_byte(8'h07, a);
    bus_start();
    send_byte(AR, a); check(a, "R10 read addr ack", a, 1);
    recv_byte(1'b1, d); check(d == exp_r[7], "R10 read reg7", d, exp_r[7]);
    recv_byte(1'b1, d); check(d == exp_r[8], "R10 read reg8", d, exp_r[8]);
    recv_byte(1'b0, d); check(d == exp_r[0], "R10 read wraps to reg0", d, exp_r[0]);
    check(sda_oe == 0, "R10 released after nack", sda_oe, 0);
    bus_stop();
    check_regs("R10 read leaves regs");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    t_reset();
    t_single();
    t_burst();
    t_wrap();
    t_high_sub();
    t_bad_addr();
    t_rep_start();
    t_read();
    check(bad_pull == 0, "R11 pull only while SCL low", bad_pull, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule